// File: doc/BRIEF.md
# Row-Buffered Sliding Window Generator

This block reads one channel of a square image, one whole row per read, from a synchronous on-chip memory. It turns that channel into a stream of square WIN×WIN pixel windows for a convolution stage that follows it. Each window is presented with all of its pixels in parallel. The block steps the window one pixel to the right on every accepted transfer. It adds no padding and uses a stride of one.

Rows are held in row-wide shift registers. Two sets of WIN row registers alternate. The row-load controller fills one set with the WIN rows of the next band while the other set shifts windows out. Because the sets alternate, the block never indexes individual pixels. When the consumer is always ready, it sustains one window per clock.

A frame begins with a start pulse. It ends with a last-window marker and a done flag. The consumer takes windows with a valid/ready handshake.

Top module: `sliding_window_gen`

## Requirements
- R1: After reset, and until a frame is started, `win_valid`, `win_last`, `mem_rd_en` and `done` are all low.
- R2: Each memory read fetches one full image row. `mem_rd_addr` is the row index. The row arrives on `mem_rd_data` in the cycle after `mem_rd_en`. Pixel x of a row sits at bits [x*PIX_W +: PIX_W].
- R3: In the window whose top-left image pixel is (row b, column x), the pixel at window row r and window column c is placed at `win_pix` bits [(r*WIN+c)*PIX_W +: PIX_W]. That field equals image pixel (b+r, x+c).
- R4: A frame delivers exactly (IMG_SIZE−WIN+1)² windows with no padding. Within a band, x runs from 0 to IMG_SIZE−WIN. The band b then advances by one row, from 0 to IMG_SIZE−WIN.
- R5: A window is consumed only when `win_valid` and `win_ready` are both high. While `win_valid` is high and `win_ready` is low, the next cycle shows `win_valid` high with the same `win_pix`.
- R6: When `win_ready` is held high and 2·WIN ≤ IMG_SIZE, windows are delivered on every cycle from the first window of the frame to the last, with no gap.
- R7: `win_last` is high together with the final window of the frame and with no other window.
- R8: `done` rises in the cycle after the final window is accepted and stays high until the next start. While `done` is high, `win_valid` and `mem_rd_en` stay low.
- R9: A `start` pulse while a frame is in progress is ignored, and the window sequence continues unchanged.
- R10: A frame issues exactly WIN reads per band, (IMG_SIZE−WIN+1)·WIN in total, and never addresses a row at or beyond IMG_SIZE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse, taken only when idle |
| mem_rd_en | output | 1 | Row read request to the image memory |
| mem_rd_addr | output | $clog2(IMG_SIZE) | Row index to read |
| mem_rd_data | input | IMG_SIZE*PIX_W | Row returned one cycle after the read |
| win_valid | output | 1 | A window is presented |
| win_ready | input | 1 | Consumer accepts the presented window |
| win_pix | output | WIN*WIN*PIX_W | All window pixels, row-major |
| win_last | output | 1 | Presented window is the final one of the frame |
| done | output | 1 | Frame finished; held until the next start |

## Verification
The bench builds the block with an 8×8 image, a 3×3 window and 8-bit pixels. That gives six bands of six windows each, so each register set is loaded and drained three times per frame. Because 2·WIN ≤ IMG_SIZE with these values, the gap-free rate claim can be checked. The image has a distinct value at every position, so a swapped row, a wrong column or a wrong band start shows up in the window compare. Varied ready patterns drive stalls at band boundaries, and a stray start is issued mid-frame.

// File: rtl/swg_pkg.sv
package swg_pkg;
   typedef enum logic {SET_A = 1'b0, SET_B = 1'b1} bank_sel_e;

   function automatic bank_sel_e other_set(bank_sel_e s);
      return (s == SET_A) ? SET_B : SET_A;
   endfunction
endpackage

// File: rtl/swg_row_loader.sv
module swg_row_loader
   import swg_pkg::*;
#(
   parameter int unsigned WIN    = 5,
   parameter int unsigned NBANDS = 76,
   parameter int unsigned AW     = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_start,
   input  logic            frame_run,
   input  logic [1:0]      bank_full,
   output logic            rd_en,
   output logic [AW-1:0]   rd_addr,
   output logic            wr_en,
   output bank_sel_e       wr_set,
   output logic [(WIN>1 ? $clog2(WIN) : 1)-1:0] wr_row
);
   localparam int unsigned RW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int unsigned BW = $clog2(NBANDS + 1);

   bank_sel_e         fill_set;
   logic [RW-1:0]     fill_row;
   logic [BW-1:0]     fill_band;

   assign rd_en   = frame_run && (fill_band < BW'(NBANDS)) && !bank_full[fill_set];
   assign rd_addr = AW'(fill_band) + AW'(fill_row);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_set  <= SET_A;
         fill_row  <= '0;
         fill_band <= '0;
      end else if (frame_start) begin
         fill_set  <= SET_A;
         fill_row  <= '0;
         fill_band <= '0;
      end else if (rd_en) begin
         if (fill_row == RW'(WIN - 1)) begin
            fill_row  <= '0;
            fill_set  <= other_set(fill_set);
            fill_band <= fill_band + 1'b1;
         end else begin
            fill_row <= fill_row + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en  <= 1'b0;
         wr_set <= SET_A;
         wr_row <= '0;
      end else begin
         wr_en  <= rd_en;
         wr_set <= fill_set;
         wr_row <= fill_row;
      end
   end
endmodule

// File: rtl/swg_row_bank.sv
module swg_row_bank #(
   parameter int unsigned WIN      = 5,
   parameter int unsigned ROW_BITS = 640,
   parameter int unsigned PIX_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic [(WIN>1 ? $clog2(WIN) : 1)-1:0] load_row,
   input  logic [ROW_BITS-1:0]       load_data,
   input  logic                      shift_en,
   output logic [WIN*WIN*PIX_W-1:0]  heads
);
   localparam int unsigned RW = (WIN > 1) ? $clog2(WIN) : 1;

   for (genvar r = 0; r < WIN; r++) begin : g_row
      logic [ROW_BITS-1:0] row_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            row_q <= '0;
         else if (load_en && load_row == RW'(r))
            row_q <= load_data;
         else if (shift_en)
            row_q <= row_q >> PIX_W;
      end

      for (genvar c = 0; c < WIN; c++) begin : g_col
         assign heads[(r*WIN + c)*PIX_W +: PIX_W] = row_q[c*PIX_W +: PIX_W];
      end
   end
endmodule

// File: rtl/swg_window_mux.sv
module swg_window_mux
   import swg_pkg::*;
#(
   parameter int unsigned BITS = 200
) (
   input  bank_sel_e         sel,
   input  logic [BITS-1:0]   from_a,
   input  logic [BITS-1:0]   from_b,
   output logic [BITS-1:0]   win
);
   assign win = (sel == SET_B) ? from_b : from_a;
endmodule

// File: rtl/sliding_window_gen.sv
module sliding_window_gen
   import swg_pkg::*;
#(
   parameter int unsigned IMG_SIZE = 80,
   parameter int unsigned WIN      = 5,
   parameter int unsigned PIX_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   output logic                          mem_rd_en,
   output logic [$clog2(IMG_SIZE)-1:0]   mem_rd_addr,
   input  logic [IMG_SIZE*PIX_W-1:0]     mem_rd_data,
   output logic                          win_valid,
   input  logic                          win_ready,
   output logic [WIN*WIN*PIX_W-1:0]      win_pix,
   output logic                          win_last,
   output logic                          done
);
   localparam int unsigned AW       = $clog2(IMG_SIZE);
   localparam int unsigned ROW_BITS = IMG_SIZE * PIX_W;
   localparam int unsigned WIN_BITS = WIN * WIN * PIX_W;
   localparam int unsigned NSPAN    = IMG_SIZE - WIN + 1;
   localparam int unsigned CW       = $clog2(NSPAN + 1);
   localparam int unsigned RW       = (WIN > 1) ? $clog2(WIN) : 1;

   if (IMG_SIZE < 2) begin : g_bad_size
      $error("IMG_SIZE must be at least 2");
   end
   if (WIN < 1 || WIN > IMG_SIZE) begin : g_bad_win
      $error("WIN must lie between 1 and IMG_SIZE");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("PIX_W must be at least 1");
   end

   logic           active;
   logic           done_q;
   logic [1:0]     full_q;
   bank_sel_e      drain_set;
   logic [CW-1:0]  col_q;
   logic [CW-1:0]  band_q;

   logic           wr_en;
   bank_sel_e      wr_set;
   logic [RW-1:0]  wr_row;

   logic           frame_start;
   logic           take;
   logic           row_end;
   logic           frame_end;
   logic [WIN_BITS-1:0] heads [2];

   assign frame_start = start && !active;
   assign win_valid   = active && full_q[drain_set];
   assign take        = win_valid && win_ready;
   assign row_end     = (col_q == CW'(NSPAN - 1));
   assign frame_end   = row_end && (band_q == CW'(NSPAN - 1));
   assign win_last    = win_valid && frame_end;
   assign done        = done_q;

   swg_row_loader #(
      .WIN    (WIN),
      .NBANDS (NSPAN),
      .AW     (AW)
   ) u_loader (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .frame_run   (active),
      .bank_full   (full_q),
      .rd_en       (mem_rd_en),
      .rd_addr     (mem_rd_addr),
      .wr_en       (wr_en),
      .wr_set      (wr_set),
      .wr_row      (wr_row)
   );

   for (genvar s = 0; s < 2; s++) begin : g_set
      logic mine_load;
      logic mine_shift;

      assign mine_load  = wr_en && (wr_set == bank_sel_e'(s));
      assign mine_shift = take && (drain_set == bank_sel_e'(s));

      swg_row_bank #(
         .WIN      (WIN),
         .ROW_BITS (ROW_BITS),
         .PIX_W    (PIX_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_en   (mine_load),
         .load_row  (wr_row),
         .load_data (mem_rd_data),
         .shift_en  (mine_shift),
         .heads     (heads[s])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)
            full_q[s] <= 1'b0;
         else if (mine_load && wr_row == RW'(WIN - 1))
            full_q[s] <= 1'b1;
         else if (mine_shift && row_end)
            full_q[s] <= 1'b0;
      end
   end

   swg_window_mux #(.BITS(WIN_BITS)) u_mux (
      .sel    (drain_set),
      .from_a (heads[0]),
      .from_b (heads[1]),
      .win    (win_pix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         done_q    <= 1'b0;
         drain_set <= SET_A;
         col_q     <= '0;
         band_q    <= '0;
      end else if (frame_start) begin
         active    <= 1'b1;
         done_q    <= 1'b0;
         drain_set <= SET_A;
         col_q     <= '0;
         band_q    <= '0;
      end else if (take) begin
         if (row_end) begin
            col_q     <= '0;
            band_q    <= band_q + 1'b1;
            drain_set <= other_set(drain_set);
            if (frame_end) begin
               active <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sliding_window_gen_chk.sv
module sliding_window_gen_chk #(
   parameter int unsigned IMG_SIZE = 80,
   parameter int unsigned WIN      = 5,
   parameter int unsigned PIX_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        mem_rd_en,
   input logic [$clog2(IMG_SIZE)-1:0] mem_rd_addr,
   input logic                        win_valid,
   input logic                        win_ready,
   input logic [WIN*WIN*PIX_W-1:0]    win_pix,
   input logic                        win_last,
   input logic                        done
);
   a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_ready) |=> (win_valid && $stable(win_pix)));

   a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      win_last |-> win_valid);

   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!win_valid && !mem_rd_en));

   a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(win_valid && win_ready && win_last));

   a_r10_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (32'(mem_rd_addr) < IMG_SIZE));
endmodule

bind sliding_window_gen sliding_window_gen_chk #(
   .IMG_SIZE (IMG_SIZE),
   .WIN      (WIN),
   .PIX_W    (PIX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .win_valid   (win_valid),
   .win_ready   (win_ready),
   .win_pix     (win_pix),
   .win_last    (win_last),
   .done        (done)
);

// File: tb/sliding_window_gen_tb.sv
module sliding_window_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int IMG  = 8;
   localparam int WN   = 3;
   localparam int PW   = 8;
   localparam int SPAN = IMG - WN + 1;
   localparam int NW   = SPAN * SPAN;
   localparam int NRD  = SPAN * WN;

   // [17] check gap-free rate, [16] stray start mid-frame, [15:0] ready pattern
   localparam logic [17:0] FRAME_VEC [5] = '{
      {1'b1, 1'b0, 16'hFFFF},
      {1'b0, 1'b0, 16'hAAAA},
      {1'b0, 1'b1, 16'h7BDE},
      {1'b0, 1'b0, 16'h0F0F},
      {1'b1, 1'b1, 16'hFFFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic win_ready = 1'b0;
   logic mem_rd_en;
   logic [2:0] mem_rd_addr;
   logic [IMG*PW-1:0] mem_rd_data = '0;
   logic win_valid;
   logic [WN*WN*PW-1:0] win_pix;
   logic win_last;
   logic done;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sliding_window_gen #(.IMG_SIZE(IMG), .WIN(WN), .PIX_W(PW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .win_valid   (win_valid),
      .win_ready   (win_ready),
      .win_pix     (win_pix),
      .win_last    (win_last),
      .done        (done)
   );

   function automatic logic [7:0] pix_val(int r, int c);
      return 8'((r * 29 + c * 11 + 3) % 256);
   endfunction

   function automatic logic [IMG*PW-1:0] row_word(int r);
      logic [IMG*PW-1:0] w;
      for (int c = 0; c < IMG; c++) w[c*PW +: PW] = pix_val(r, c);
      return w;
   endfunction

   function automatic logic [WN*WN*PW-1:0] exp_win(int k);
      logic [WN*WN*PW-1:0] w;
      int b;
      int x;
      b = k / SPAN;
      x = k % SPAN;
      for (int r = 0; r < WN; r++)
         for (int c = 0; c < WN; c++)
            w[(r*WN + c)*PW +: PW] = pix_val(b + r, x + c);
      return w;
   endfunction

   // R2: image memory, one row per word, data one cycle after the read
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= row_word(int'(mem_rd_addr));

   task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_idle(string tag);
      check(!win_valid && !win_last && !mem_rd_en && !done, tag,
            {win_valid, win_last, mem_rd_en, done}, 4'b0000);
   endtask

   task automatic run_frame(logic [17:0] vec);
      int k = 0;
      int reads = 0;
      int cyc = 0;
      int gaps = 0;
      bit prev_stall = 0;
      logic [WN*WN*PW-1:0] prev_pix = '0;
      start = 1'b1;
      @(negedge clk);
      while (k < NW && cyc < 3000) begin
         win_ready = vec[cyc % 16];
         start = (vec[16] && k == 10) ? 1'b1 : 1'b0;   // R9 stray start
         if (mem_rd_en) reads++;
         if (prev_stall)
            check(win_valid && win_pix == prev_pix, "R5 stall hold",
                  {win_valid, win_pix}, {1'b1, prev_pix});
         if (k > 0 && win_ready && !win_valid) gaps++;
         if (win_valid && win_ready) begin
            check(win_pix == exp_win(k), "R3/R4/R9 window content", win_pix, exp_win(k));
            check(win_last == (k == NW - 1), "R7 last flag", win_last, (k == NW - 1));
            k++;
         end
         prev_stall = win_valid && !win_ready;
         prev_pix = win_pix;
         cyc++;
         @(negedge clk);
      end
      start = 1'b0;
      win_ready = 1'b0;
      check(k == NW, "R4 window count", k, NW);
      check(done && !win_valid, "R8 done after last", {done, win_valid}, 2'b10);
      check(reads == NRD, "R10 read count", reads, NRD);
      if (vec[17]) check(gaps == 0, "R6 gap-free rate", gaps, 0);
      repeat (3) @(negedge clk);
      check(done && !win_valid && !mem_rd_en, "R8 done held and quiet",
            {done, win_valid, mem_rd_en}, 3'b100);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 idle in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_idle("R1 idle after reset");

      for (int i = 0; i < 5; i++) run_frame(FRAME_VEC[i]);

      // reset during a frame returns to idle, then a full frame still works
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      win_ready = 1'b1;
      repeat (12) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      win_ready = 1'b0;
      @(negedge clk);
      check_idle("R1 idle after mid-frame reset");
      run_frame({1'b1, 1'b0, 16'hFFFF});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule